// File: doc/BRIEF.md
# Accumulate-Mode Final Padding Detector

This block sits beside a hash core that receives one message as a series of requests. Software appends the standard hash padding to the last request itself: a 0x80 marker byte, zero bytes, and a trailing 64-bit big-endian count of message bits. No descriptor flag says which request is the last one. The block works this out from the data.

Each request arrives as a byte stream, with a start flag on its first byte and an end flag on its last byte. The block stores the bytes in a small RAM and keeps the final eight bytes in a shift register. It also keeps a running byte total across the requests. When the request ends, the block reads the trailer as a claimed message length. From that length and the running total it works out where the padding would begin. It then reads the stored byte at that position to confirm the marker.

The block then reports one decision for the request. The decision says whether the request closes the message, and gives how many of its bytes are payload for the hash core.

Top module: `accum_pad_detect`

## Requirements
- R1: The running total is the sum of the byte lengths of every request since reset, `clr` or the last final request. It includes the current request's length before the judgement is made.
- R2: The trailer is the last eight bytes of the request. The last byte is the least significant byte. In a request shorter than eight bytes, the missing upper bytes read as zero. The claimed length in bytes is the trailer value shifted right by three.
- R3: A request whose claimed length exceeds the running total is not final.
- R4: With pad = total − claimed, the pad offset is the request length minus pad. If the offset is not inside the request (negative, or equal to the request length), the request is not final.
- R5: A request is final only when its byte at the pad offset (offset 0 = first byte) equals 0x80. Its reported payload length is then the pad offset.
- R6: A request judged not final reports its full length as payload. The running total is kept.
- R7: A final request resets the running total to zero, so the next request starts a new message.
- R8: A synchronous `clr` zeroes the running total, drops any partly received request and cancels a pending decision.
- R9: `res_valid` is a one-cycle pulse that appears on the second rising edge after the edge that accepts the end-of-request byte. `res_final` and `res_len` hold until the next decision. After reset, all three outputs are zero.
- R10: Input bytes offered during the two cycles between an accepted end-of-request byte and its decision are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of total and pending state |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_sop | input | 1 | Byte is the first of a request |
| in_eop | input | 1 | Byte is the last of a request |
| in_byte | input | 8 | Request data byte |
| res_valid | output | 1 | Decision pulse |
| res_final | output | 1 | Request holds the padding |
| res_len | output | LEN_W | Payload bytes of the request |

## Verification
Whole padded messages with random payloads are cut into requests of random sizes. This shows whether the padding is found in the request that actually carries it. It also shows that earlier requests, including ones that happen to end in random data, pass through as full-length payload.

Directed messages then isolate each branch of the decision:
- A claimed length above the total.
- A pad of exactly zero.
- A negative offset.
- A missing marker.
- A single-byte request whose zero-filled trailer decides the outcome.

Runs that are cleared mid-request, or that follow a final request, distinguish a running total that truly restarts from one that leaks over. Junk bytes offered while a decision is pending show whether the input is really blocked.

// File: rtl/accum_pad_pkg.sv
package accum_pad_pkg;
  localparam int TRAIL_BYTES = 8;
  localparam int TRAIL_W     = TRAIL_BYTES * 8;
  localparam logic [7:0] PAD_MARK = 8'h80;
  typedef logic [TRAIL_W-1:0] trailer_t;
  typedef logic [7:0]         byte_t;
endpackage

// File: rtl/apd_byte_ram.sv
module apd_byte_ram #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/apd_capture.sv
module apd_capture
  import accum_pad_pkg::*;
#(
  parameter int MAX_REQ = 64,
  parameter int LEN_W   = 7,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              accept,
  input  logic              sop,
  input  logic              eop,
  input  byte_t             din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output byte_t             wr_data,
  output logic              req_done,
  output logic [LEN_W-1:0]  req_len,
  output trailer_t          trailer
);
  logic [LEN_W-1:0] cnt, ncnt;
  logic             room;

  // Bytes beyond MAX_REQ are neither stored nor counted.
  assign room    = cnt < LEN_W'(MAX_REQ);
  assign ncnt    = sop ? LEN_W'(1) : (room ? cnt + LEN_W'(1) : cnt);
  assign wr_en   = accept && (sop || room);
  assign wr_addr = sop ? '0 : cnt[ADDR_W-1:0];
  assign wr_data = din;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt      <= '0;
      trailer  <= '0;
      req_done <= 1'b0;
      req_len  <= '0;
    end else begin
      req_done <= accept && eop;
      if (accept) begin
        cnt     <= ncnt;
        // A new request starts with a zero-filled trailer (R2).
        trailer <= sop ? {{(TRAIL_W-8){1'b0}}, din} : {trailer[TRAIL_W-9:0], din};
        if (eop) req_len <= ncnt;
      end
    end
  end

  // R10: nothing is captured while input is blocked.
  p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (!accept && !clr) |=> ($stable(cnt) && $stable(trailer)));
endmodule

// File: rtl/apd_judge.sv
module apd_judge
  import accum_pad_pkg::*;
#(
  parameter int LEN_W   = 7,
  parameter int ADDR_W  = 6,
  parameter int TOTAL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              req_done,
  input  logic [LEN_W-1:0]  req_len,
  input  trailer_t          trailer,
  input  byte_t             rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              res_valid,
  output logic              res_final,
  output logic [LEN_W-1:0]  res_len
);
  logic [TOTAL_W-1:0] total, total_new, pad, tot_q;
  logic [TRAIL_W-1:0] claim64, tot64;
  logic               claim_ok, in_range, look, hit_q, fin;
  logic [LEN_W-1:0]   offset, off_q, len_q;

  // Stage 1: arithmetic on the finished request (R1-R4).
  assign total_new = total + TOTAL_W'(req_len);
  assign claim64   = {3'b000, trailer[TRAIL_W-1:3]};
  assign tot64     = TRAIL_W'(total_new);
  assign claim_ok  = claim64 <= tot64;
  assign pad       = total_new - TOTAL_W'(claim64);
  assign in_range  = claim_ok && (pad != '0) && (pad <= TOTAL_W'(req_len));
  assign offset    = req_len - LEN_W'(pad);
  assign rd_addr   = offset[ADDR_W-1:0];
  assign busy      = req_done || look;

  // Stage 2: marker test on the byte read back (R5).
  assign fin = hit_q && (rd_data == PAD_MARK);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      look      <= 1'b0;
      hit_q     <= 1'b0;
      off_q     <= '0;
      len_q     <= '0;
      tot_q     <= '0;
      total     <= '0;
      res_valid <= 1'b0;
      res_final <= 1'b0;
      res_len   <= '0;
    end else begin
      look      <= req_done;
      res_valid <= look;
      if (req_done) begin
        hit_q <= in_range;
        off_q <= offset;
        len_q <= req_len;
        tot_q <= total_new;
      end
      if (look) begin
        res_final <= fin;
        res_len   <= fin ? off_q : len_q;
        total     <= fin ? '0 : tot_q;
      end
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (look && !clr) |=> res_valid);
  p_final_len_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_final) |-> (res_len < len_q));
  p_total_reset_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_final) |-> (total == '0));
  p_clr_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!res_valid && total == '0 && !look));
endmodule

// File: rtl/accum_pad_detect.sv
module accum_pad_detect
  import accum_pad_pkg::*;
#(
  parameter  int MAX_REQ = 64,
  parameter  int TOTAL_W = 32,
  localparam int LEN_W   = $clog2(MAX_REQ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_byte,
  output logic             res_valid,
  output logic             res_final,
  output logic [LEN_W-1:0] res_len
);
  localparam int ADDR_W = (MAX_REQ > 1) ? $clog2(MAX_REQ) : 1;

  logic              accept, busy, wr_en, req_done;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  byte_t             wr_data, rd_data;
  logic [LEN_W-1:0]  cap_len;
  trailer_t          trailer;

  assign accept = in_valid && !busy;

  apd_capture #(.MAX_REQ(MAX_REQ), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .clr(clr), .accept(accept), .sop(in_sop), .eop(in_eop),
    .din(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_done(req_done), .req_len(cap_len), .trailer(trailer));

  apd_byte_ram #(.DEPTH(MAX_REQ), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data));

  apd_judge #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .TOTAL_W(TOTAL_W)) u_judge (
    .clk(clk), .rst(rst), .clr(clr), .req_done(req_done), .req_len(cap_len),
    .trailer(trailer), .rd_data(rd_data), .rd_addr(rd_addr), .busy(busy),
    .res_valid(res_valid), .res_final(res_final), .res_len(res_len));

  // R6: a non-final decision passes the whole request length.
  p_nonfinal_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_final) |-> (res_len == cap_len));
endmodule

// File: tb/accum_pad_detect_test.sv
module accum_pad_detect_test;
  localparam int MAX_REQ = 64;
  localparam int LEN_W   = $clog2(MAX_REQ + 1);

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic res_valid, res_final;
  logic [LEN_W-1:0] res_len;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  longint unsigned model_total = 0;
  logic [7:0] rq  [MAX_REQ];
  logic [7:0] msg [256];

  always #4 clk = ~clk;

  accum_pad_detect #(.MAX_REQ(MAX_REQ)) uut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_byte(in_byte), .res_valid(res_valid),
    .res_final(res_final), .res_len(res_len));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Reference decision computed from the requirements.
  task automatic model_req(input int n, output bit fin, output int plen);
    logic [63:0] tr = '0;
    longint unsigned claimed, pad;
    for (int i = 0; i < n; i++) tr = {tr[55:0], rq[i]};
    model_total += longint'(n);
    claimed = tr >> 3;
    fin = 1'b0;
    pad = 0;
    if (claimed <= model_total) begin
      pad = model_total - claimed;
      if (pad >= 1 && pad <= longint'(n) && rq[n - int'(pad)] == 8'h80) fin = 1'b1;
    end
    plen = fin ? n - int'(pad) : n;
    if (fin) model_total = 0;
  endtask

  task automatic send_bytes(input int n, input bit with_eop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = with_eop && (i == n - 1);
      in_byte  = rq[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic do_req(input int n, input string tag_f, input string tag_n);
    bit efin; int elen; bit early;
    logic [10:0] act, exp;
    model_req(n, efin, elen);
    send_bytes(n, 1'b1);
    early = res_valid;
    @(negedge clk);
    early = early | res_valid;
    @(negedge clk);
    act = {early, res_valid, res_final, 8'(res_len)};
    exp = {1'b0, 1'b1, efin, 8'(elen)};
    check(act == exp, efin ? tag_f : tag_n, act, exp);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_total = 0;
  endtask

  task automatic send_chunk(input int off, input int n, input string tag_f, input string tag_n);
    for (int i = 0; i < n; i++) rq[i] = msg[off + i];
    do_req(n, tag_f, tag_n);
  endtask

  // Payload of L bytes, marker, zeros, 64-bit big-endian bit count; P bytes in all.
  task automatic fill_pad(input int L, input int P, input bit rnd);
    logic [63:0] bits = 64'(L) * 64'd8;
    for (int i = 0; i < P; i++) msg[i] = 8'h00;
    for (int i = 0; i < L; i++) msg[i] = rnd ? 8'($urandom) : 8'(8'h30 + i);
    msg[L] = 8'h80;
    for (int i = 0; i < 8; i++) msg[P - 8 + i] = bits[63 - 8*i -: 8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset values.
    check(!res_valid && !res_final && res_len == '0, "R9",
          {res_valid, res_final, 8'(res_len)}, 0);

    // R5 / R7: one-request message, then a second that only works after a reset total.
    fill_pad(20, 64, 1'b0); send_chunk(0, 64, "R5", "R5");
    fill_pad(5, 16, 1'b0);  send_chunk(0, 16, "R7", "R7");

    // R3 / R6 then R1: two-request message, total spans both.
    fill_pad(40, 64, 1'b0);
    for (int i = 0; i < 30; i++) msg[i] = 8'h11;
    send_chunk(0, 30, "R3", "R3");
    send_chunk(30, 34, "R1", "R1");

    // R4: pad of zero puts the offset just past the request.
    for (int i = 0; i < 16; i++) rq[i] = 8'h80;
    rq[8] = 8'h00; rq[9] = 8'h00; rq[10] = 8'h00; rq[11] = 8'h00;
    rq[12] = 8'h00; rq[13] = 8'h00; rq[14] = 8'h00; rq[15] = 8'h80;
    do_req(16, "R4", "R4");
    do_clear();

    // R4: negative offset.
    for (int i = 0; i < 40; i++) rq[i] = 8'h00;
    rq[0] = 8'h22; rq[5] = 8'h80;
    do_req(40, "R6", "R6");
    for (int i = 0; i < 24; i++) rq[i] = 8'h00;
    rq[23] = 8'h28;
    do_req(24, "R4", "R4");
    do_clear();

    // R5: marker missing at the offset.
    fill_pad(5, 16, 1'b0); msg[5] = 8'h7f;
    send_chunk(0, 16, "R5", "R5");
    do_clear();

    // R2: one-byte request, zero-filled trailer gives 16 claimed bytes.
    for (int i = 0; i < 16; i++) rq[i] = 8'hff;
    do_req(16, "R2", "R2");
    rq[0] = 8'h80;
    do_req(1, "R2", "R2");

    // R8: clear mid-request after a non-final request.
    for (int i = 0; i < 30; i++) rq[i] = 8'h11;
    do_req(30, "R8", "R8");
    send_bytes(5, 1'b0);
    do_clear();
    fill_pad(5, 16, 1'b0); send_chunk(0, 16, "R8", "R8");

    // R10: junk offered while the decision is pending.
    begin
      bit efin; int elen; bit extra;
      fill_pad(9, 32, 1'b0);
      for (int i = 0; i < 32; i++) rq[i] = msg[i];
      model_req(32, efin, elen);
      send_bytes(32, 1'b1);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_byte = 8'h80;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      check(res_valid && res_final == efin && res_len == elen, "R10",
            {res_valid, res_final, 8'(res_len)}, {1'b1, efin, 8'(elen)});
      extra = 1'b0;
      repeat (3) begin @(negedge clk); extra = extra | res_valid; end
      check(!extra, "R10", extra, 0);
      fill_pad(3, 16, 1'b0); send_chunk(0, 16, "R10", "R10");
    end

    // Random padded messages split into random requests.
    for (int m = 0; m < 40; m++) begin
      int L, P, off;
      L = int'($urandom % 120);
      P = ((L + 9 + 63) / 64) * 64;
      fill_pad(L, P, 1'b1);
      off = 0;
      while (off < P) begin
        int n;
        n = 1 + int'($urandom % MAX_REQ);
        if (n > P - off) n = P - off;
        send_chunk(off, n, "R5", "R6");
        off += n;
      end
      do_clear();
    end

    report();
  end
endmodule